// File: doc/BRIEF.md
# ATA strobe timing generator

This block produces the active-low read and write strobes for programmed I/O and multiword DMA cycles on a parallel ATA bus. Each access is timed from a 32-bit per-device timing word. That word holds two sets of phase counts. One set applies to data-port transfers and the other to task-file register accesses. A one-bit selector picks between them when the request is accepted.

A requester raises `req_i` and supplies the direction, the task-file selector, a continue flag and the timing word. The block acknowledges in the same cycle whenever it can accept. It then runs three phases, counted in bus clock cycles: a setup phase with both strobes high, an active phase with one strobe low, and a recovery phase with the strobe high again. `done_o` pulses in the last recovery cycle. When an access was flagged as continuing, a request held during that done cycle is chained. The chained access starts straight in the active phase and has no setup phase. The Ultra DMA and mode-enable fields of the captured word are only decoded and driven out.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset both strobes are high, `busy_o`, `done_o` and `ack_o` are 0, and all decoded mode outputs are 0.
- R2: In idle, `ack_o` equals `req_i` in the same cycle. On the acknowledging clock edge the timing word, direction, selector and continue flag are captured. Changes to these inputs after that edge do not alter the timing or the mode outputs of the running access.
- R3: With `tf_i`=0, the setup phase lasts bits 24:22 + 1 cycles, the active phase bits 8:4 + 1 cycles and the recovery phase bits 3:0 + 1 cycles. All-zero fields give one cycle per phase.
- R4: With `tf_i`=1, the setup phase lasts bits 27:25 + 1 cycles, the active phase bits 17:13 + 1 cycles and the recovery phase bits 12:9 + 1 cycles.
- R5: A read (`wr_i`=0) drives only `rd_strb_n_o` low and a write (`wr_i`=1) drives only `wr_strb_n_o` low. The two strobes are never low together.
- R6: `done_o` is high for exactly one cycle, the last cycle of the recovery phase. `busy_o` is high from the cycle after acceptance through that done cycle.
- R7: While busy, `ack_o` stays 0 whatever `req_i` does. The only exception is the chaining case of R8.
- R8: If the running access was accepted with `cont_i`=1 and `req_i` is high in its done cycle, `ack_o` is 1 in that cycle. The new access then begins in the active phase on the next cycle, with no setup phase.
- R9: The mode outputs show fields of the captured word: `udma_cyc_o` = bits 20:18, `udma_2x_o` = bit 21 (1 = doubled clock), `udma_en_o` = bit 28, `dma_en_o` = bit 29, `pio_bm_en_o` = bit 30, `fifo_en_o` = bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| tf_i | input | 1 | 1 = task-file register timing, 0 = data-port timing |
| cont_i | input | 1 | Access is part of a continuing burst |
| tword_i | input | 32 | Per-device timing word |
| ack_o | output | 1 | Request accepted this cycle |
| busy_o | output | 1 | An access is in progress |
| done_o | output | 1 | Last cycle of the running access |
| rd_strb_n_o | output | 1 | Active-low read strobe |
| wr_strb_n_o | output | 1 | Active-low write strobe |
| udma_cyc_o | output | 3 | Ultra DMA cycle count field |
| udma_2x_o | output | 1 | Ultra DMA clock select, 1 = doubled |
| udma_en_o | output | 1 | Ultra DMA enable field |
| dma_en_o | output | 1 | DMA enable field |
| pio_bm_en_o | output | 1 | Bus-master-during-PIO enable field |
| fifo_en_o | output | 1 | FIFO enable field (PIO only) |

## Verification
The hardest situation to reach is the chained access. It needs a continuing access to be running and `req_i` to be held high during exactly the cycle that `done_o` pulses. The bench holds the request high across the whole first access, with a second, different timing word already on the inputs. This also shows that the block ignores the request in every busy cycle before done. The bench then checks that the acknowledge falls in the done cycle and that the second access opens with its strobe already low. A second held-request scenario with the continue flag clear shows that the done cycle alone does not accept a request.

// File: rtl/ata_strobe_pkg.sv
// Package: field layout of the timing word, phase encoding and decode helpers
// shared by the strobe generator modules. Assumes a 32-bit timing word.
package ata_strobe_pkg;

    localparam int TW_W   = 32;
    localparam int HI_W   = 4;
    localparam int LO_W   = 5;
    localparam int PRE_W  = 3;
    localparam int UCYC_W = 3;

    // Field positions inside the timing word
    localparam int D_HI_LSB  = 0;
    localparam int D_LO_LSB  = 4;
    localparam int T_HI_LSB  = 9;
    localparam int T_LO_LSB  = 13;
    localparam int UCYC_LSB  = 18;
    localparam int U2X_BIT   = 21;
    localparam int D_PRE_LSB = 22;
    localparam int T_PRE_LSB = 25;
    localparam int UEN_BIT   = 28;
    localparam int DEN_BIT   = 29;
    localparam int BM_BIT    = 30;
    localparam int FEN_BIT   = 31;

    localparam int CNT_W_HL = (LO_W > HI_W) ? LO_W : HI_W;
    localparam int CNT_W    = (CNT_W_HL > PRE_W) ? CNT_W_HL : PRE_W;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_ACTIVE  = 2'd2,
        PH_RECOVER = 2'd3
    } phase_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [LO_W-1:0]  lo;
        logic [HI_W-1:0]  hi;
    } phase_cfg_t;

    typedef struct packed {
        logic              fifo_en;
        logic              bm_en;
        logic              dma_en;
        logic              udma_en;
        logic              udma_2x;
        logic [UCYC_W-1:0] udma_cyc;
    } mode_t;

    // Pick the data-port or task-file phase counts out of a timing word
    function automatic phase_cfg_t pick_cfg(input logic [TW_W-1:0] w, input logic tf);
        phase_cfg_t c;
        if (tf) begin
            c.pre = w[T_PRE_LSB +: PRE_W];
            c.lo  = w[T_LO_LSB  +: LO_W];
            c.hi  = w[T_HI_LSB  +: HI_W];
        end else begin
            c.pre = w[D_PRE_LSB +: PRE_W];
            c.lo  = w[D_LO_LSB  +: LO_W];
            c.hi  = w[D_HI_LSB  +: HI_W];
        end
        return c;
    endfunction

    // Extract the exported mode and Ultra DMA fields
    function automatic mode_t pick_mode(input logic [TW_W-1:0] w);
        mode_t m;
        m.fifo_en  = w[FEN_BIT];
        m.bm_en    = w[BM_BIT];
        m.dma_en   = w[DEN_BIT];
        m.udma_en  = w[UEN_BIT];
        m.udma_2x  = w[U2X_BIT];
        m.udma_cyc = w[UCYC_LSB +: UCYC_W];
        return m;
    endfunction

endpackage

// File: rtl/ata_tw_latch.sv
// Module: holds the timing word and access flags captured at acceptance.
// It provides the phase counts of the incoming request (used on the accepting
// edge) and of the captured request (used for later phases).
// Assumes cap_i is high only on an accepting cycle.
module ata_tw_latch
    import ata_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [TW_W-1:0]  tword_i,
    input  logic             tf_i,
    input  logic             wr_i,
    input  logic             cont_i,
    output phase_cfg_t       cfg_in_o,
    output phase_cfg_t       cfg_q_o,
    output mode_t            mode_q_o,
    output logic             wr_q_o,
    output logic             cont_q_o
);

    logic [TW_W-1:0] word_q;
    logic            tf_q;

    // Capture the request attributes on acceptance, hold them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            tf_q     <= 1'b0;
            wr_q_o   <= 1'b0;
            cont_q_o <= 1'b0;
        end else if (cap_i) begin
            word_q   <= tword_i;
            tf_q     <= tf_i;
            wr_q_o   <= wr_i;
            cont_q_o <= cont_i;
        end
    end

    // Decode incoming and captured phase counts plus exported fields
    always_comb begin
        cfg_in_o = pick_cfg(tword_i, tf_i);
        cfg_q_o  = pick_cfg(word_q, tf_q);
        mode_q_o = pick_mode(word_q);
    end

    // R2
    cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (cfg_q_o == $past(cfg_in_o)));

endmodule

// File: rtl/ata_phase_cnt.sv
// Module: down counter for the length of one phase. A load sets the counter
// to the field value; the phase ends in the cycle the count reads zero, so a
// phase lasts field value + 1 cycles. Assumes loads come only from the sequencer.
module ata_phase_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);

    // Load a new phase length or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (load_i)
            cnt_o <= val_i;
        else if (cnt_o != '0)
            cnt_o <= cnt_o - 1'b1;
    end

    // Flag the last cycle of the phase
    always_comb zero_o = (cnt_o == '0);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (cnt_o == $past(cnt_o) - 1'b1));

endmodule

// File: rtl/ata_phase_fsm.sv
// Module: phase sequencer. It accepts requests, steps through the setup,
// active and recovery phases, chains continuing bursts, and registers the
// two strobes. Assumes the counter reports zero in a phase's last cycle.
module ata_phase_fsm
    import ata_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             wr_i,
    input  phase_cfg_t       cfg_in_i,
    input  phase_cfg_t       cfg_q_i,
    input  logic             wr_q_i,
    input  logic             cont_q_i,
    input  logic             cnt_zero_i,
    output logic             ack_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             rd_strb_n_o,
    output logic             wr_strb_n_o,
    output phase_e           state_o
);

    phase_e state_q, state_d;
    logic   ready;
    logic   last_rec;
    logic   wr_next;

    // Decode acceptance, next phase and the counter load for that phase
    always_comb begin
        last_rec   = (state_q == PH_RECOVER) && cnt_zero_i;
        ready      = (state_q == PH_IDLE) || (last_rec && cont_q_i);
        ack_o      = req_i && ready;
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = '0;
        unique case (state_q)
            PH_IDLE: if (ack_o) begin
                state_d    = PH_SETUP;
                load_o     = 1'b1;
                load_val_o = CNT_W'(cfg_in_i.pre);
            end
            PH_SETUP: if (cnt_zero_i) begin
                state_d    = PH_ACTIVE;
                load_o     = 1'b1;
                load_val_o = CNT_W'(cfg_q_i.lo);
            end
            PH_ACTIVE: if (cnt_zero_i) begin
                state_d    = PH_RECOVER;
                load_o     = 1'b1;
                load_val_o = CNT_W'(cfg_q_i.hi);
            end
            PH_RECOVER: if (cnt_zero_i) begin
                if (ack_o) begin
                    state_d    = PH_ACTIVE;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(cfg_in_i.lo);
                end else begin
                    state_d    = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
        wr_next = ack_o ? wr_i : wr_q_i;
    end

    // Advance the phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // Register the strobes from the next phase so they change with the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_strb_n_o <= 1'b1;
            wr_strb_n_o <= 1'b1;
        end else begin
            rd_strb_n_o <= !((state_d == PH_ACTIVE) && !wr_next);
            wr_strb_n_o <= !((state_d == PH_ACTIVE) &&  wr_next);
        end
    end

    // Status drawn from the phase register
    always_comb begin
        busy_o  = (state_q != PH_IDLE);
        done_o  = last_rec;
        state_o = state_q;
    end

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strb_n_o && !wr_strb_n_o));

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_ACTIVE) |-> (rd_strb_n_o && wr_strb_n_o));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    chain_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && busy_o) |=> (state_q == PH_ACTIVE));

endmodule

// File: rtl/ata_strobe_gen.sv
// Module: top of the ATA strobe timing generator. It ties the word latch,
// phase counter and sequencer together and exports the decoded mode fields.
// Assumes one request source and a single bus clock.
module ata_strobe_gen
    import ata_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic              tf_i,
    input  logic              cont_i,
    input  logic [31:0]       tword_i,
    output logic              ack_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_strb_n_o,
    output logic              wr_strb_n_o,
    output logic [2:0]        udma_cyc_o,
    output logic              udma_2x_o,
    output logic              udma_en_o,
    output logic              dma_en_o,
    output logic              pio_bm_en_o,
    output logic              fifo_en_o
);

    phase_cfg_t       cfg_in, cfg_q;
    mode_t            mode_q;
    logic             wr_q, cont_q;
    logic             load;
    logic [CNT_W-1:0] load_val, cnt;
    logic             cnt_zero;
    phase_e           state;

    ata_tw_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (ack_o),
        .tword_i  (tword_i),
        .tf_i     (tf_i),
        .wr_i     (wr_i),
        .cont_i   (cont_i),
        .cfg_in_o (cfg_in),
        .cfg_q_o  (cfg_q),
        .mode_q_o (mode_q),
        .wr_q_o   (wr_q),
        .cont_q_o (cont_q)
    );

    ata_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .val_i  (load_val),
        .cnt_o  (cnt),
        .zero_o (cnt_zero)
    );

    ata_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .wr_i        (wr_i),
        .cfg_in_i    (cfg_in),
        .cfg_q_i     (cfg_q),
        .wr_q_i      (wr_q),
        .cont_q_i    (cont_q),
        .cnt_zero_i  (cnt_zero),
        .ack_o       (ack_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .load_o      (load),
        .load_val_o  (load_val),
        .rd_strb_n_o (rd_strb_n_o),
        .wr_strb_n_o (wr_strb_n_o),
        .state_o     (state)
    );

    // Drive the decoded mode fields of the captured word
    always_comb begin
        udma_cyc_o  = mode_q.udma_cyc;
        udma_2x_o   = mode_q.udma_2x;
        udma_en_o   = mode_q.udma_en;
        dma_en_o    = mode_q.dma_en;
        pio_bm_en_o = mode_q.bm_en;
        fifo_en_o   = mode_q.fifo_en;
    end

    // R3
    act_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_ACTIVE) |-> (cnt <= CNT_W'(cfg_q.lo)));

    // R7
    busy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |-> !ack_o);

endmodule

// File: tb/test_ata_strobe_gen.sv
`timescale 1ns/1ps
module test_ata_strobe_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, wr_i = 1'b0, tf_i = 1'b0, cont_i = 1'b0;
    logic [31:0] tword_i = '0;
    logic        ack_o, busy_o, done_o, rd_strb_n_o, wr_strb_n_o;
    logic [2:0]  udma_cyc_o;
    logic        udma_2x_o, udma_en_o, dma_en_o, pio_bm_en_o, fifo_en_o;

    int total = 0;
    int bad   = 0;

    // results of the last measured access
    int m_s, m_a, m_r, m_other, m_busy, m_shape, m_ack;
    logic m_ack_done, m_done_seen;

    always #2 clk = ~clk;

    ata_strobe_gen i_ata_strobe_gen (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .tf_i(tf_i),
        .cont_i(cont_i), .tword_i(tword_i), .ack_o(ack_o), .busy_o(busy_o),
        .done_o(done_o), .rd_strb_n_o(rd_strb_n_o), .wr_strb_n_o(wr_strb_n_o),
        .udma_cyc_o(udma_cyc_o), .udma_2x_o(udma_2x_o), .udma_en_o(udma_en_o),
        .dma_en_o(dma_en_o), .pio_bm_en_o(pio_bm_en_o), .fifo_en_o(fifo_en_o)
    );

    function automatic logic [31:0] mk(input int dhi, input int dlo, input int thi,
                                       input int tlo, input int ucyc, input int u2x,
                                       input int dpre, input int tpre, input int en);
        logic [31:0] w;
        w = '0;
        w[3:0]   = dhi[3:0];
        w[8:4]   = dlo[4:0];
        w[12:9]  = thi[3:0];
        w[17:13] = tlo[4:0];
        w[20:18] = ucyc[2:0];
        w[21]    = u2x[0];
        w[24:22] = dpre[2:0];
        w[27:25] = tpre[2:0];
        w[31:28] = en[3:0];
        return w;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sample one access cycle by cycle, from its first cycle up to done
    task automatic measure(input logic wr);
        int ph;
        logic tgt, oth;
        m_s = 0; m_a = 0; m_r = 0; m_other = 0; m_busy = 0; m_shape = 0; m_ack = 0;
        m_ack_done = 1'b0; m_done_seen = 1'b0; ph = 0;
        for (int i = 0; i < 200 && !m_done_seen; i++) begin
            if (i > 0) @(negedge clk);
            #1;
            tgt = wr ? wr_strb_n_o : rd_strb_n_o;
            oth = wr ? rd_strb_n_o : wr_strb_n_o;
            if (!oth) m_other++;
            if (!busy_o) m_busy++;
            case (ph)
                0: if (tgt) m_s++; else begin ph = 1; m_a++; end
                1: if (!tgt) m_a++; else begin ph = 2; m_r++; end
                default: if (!tgt) m_shape++; else m_r++;
            endcase
            if (done_o) begin
                m_done_seen = 1'b1;
                m_ack_done  = ack_o;
                if (ph != 2) m_shape++;
            end else if (ack_o) m_ack++;
        end
    endtask

    // Raise a request at a falling edge and confirm the same-cycle acknowledge
    task automatic issue(input logic [31:0] w, input logic wr, input logic tf,
                         input logic cont, input string tag);
        @(negedge clk);
        tword_i = w; wr_i = wr; tf_i = tf; cont_i = cont; req_i = 1'b1;
        #1;
        chk({tag, " R2 ack in idle"}, int'(ack_o), 1);
    endtask

    task automatic check_shape(input string tag, input int es, input int ea, input int er);
        chk({tag, " setup"},   m_s, es);
        chk({tag, " active"},  m_a, ea);
        chk({tag, " recover"}, m_r, er);
        chk({tag, " R5 other strobe high"}, m_other, 0);
        chk({tag, " R6 busy through access"}, m_busy, 0);
        chk({tag, " R6 done seen at end"}, int'(m_done_seen) + m_shape, 1);
    endtask

    task automatic after_done(input string tag);
        @(negedge clk); #1;
        chk({tag, " R6 done one cycle"}, int'(done_o), 0);
        chk({tag, " R6 idle after done"}, int'(busy_o), 0);
        chk({tag, " R1 strobes high in idle"}, int'(rd_strb_n_o && wr_strb_n_o), 1);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 rd strobe", int'(rd_strb_n_o), 1);
        chk("R1 wr strobe", int'(wr_strb_n_o), 1);
        chk("R1 busy/done/ack", int'({busy_o, done_o, ack_o}), 0);
        chk("R1 mode outputs", int'({udma_cyc_o, udma_2x_o, udma_en_o, dma_en_o, pio_bm_en_o, fifo_en_o}), 0);
    endtask

    // R3 / R9: data-port read with distinct fields
    task automatic t_data_read();
        issue(mk(3, 5, 9, 20, 5, 1, 2, 6, 4'b1010), 1'b0, 1'b0, 1'b0, "rd");
        @(negedge clk); req_i = 1'b0;
        measure(1'b0);
        check_shape("R3 data read", 3, 6, 4);
        chk("R9 udma cycles", int'(udma_cyc_o), 5);
        chk("R9 udma 2x", int'(udma_2x_o), 1);
        chk("R9 enables", int'({fifo_en_o, pio_bm_en_o, dma_en_o, udma_en_o}), 4'b1010);
        after_done("rd");
    endtask

    // R3 / R5: write with all-zero fields
    task automatic t_data_write_min();
        issue(mk(0, 0, 7, 7, 0, 0, 0, 5, 4'b0101), 1'b1, 1'b0, 1'b0, "wrmin");
        @(negedge clk); req_i = 1'b0;
        measure(1'b1);
        check_shape("R3 R5 zero fields write", 1, 1, 1);
        chk("R9 enables b", int'({fifo_en_o, pio_bm_en_o, dma_en_o, udma_en_o}), 4'b0101);
        after_done("wrmin");
    endtask

    // R4: task-file timing with maximal task-file fields
    task automatic t_taskfile();
        issue(mk(1, 2, 15, 31, 0, 0, 1, 7, 0), 1'b0, 1'b1, 1'b0, "tf");
        @(negedge clk); req_i = 1'b0;
        measure(1'b0);
        check_shape("R4 task file", 8, 32, 16);
        after_done("tf");
    endtask

    // R7 / R2: request held while busy with other inputs, no continue flag
    task automatic t_busy_ignore();
        issue(mk(2, 4, 0, 0, 0, 0, 1, 0, 4'b0001), 1'b1, 1'b0, 1'b0, "ign");
        @(negedge clk);
        tword_i = mk(15, 31, 15, 31, 7, 1, 7, 7, 4'b1110); tf_i = 1'b1; wr_i = 1'b0;
        measure(1'b1);
        check_shape("R2 held inputs ignored", 2, 5, 3);
        chk("R7 no ack while busy", m_ack, 0);
        chk("R7 no ack at done without continue", int'(m_ack_done), 0);
        chk("R2 mode held", int'({fifo_en_o, pio_bm_en_o, dma_en_o, udma_en_o, udma_cyc_o}), 7'b0001000);
        req_i = 1'b0;
        after_done("ign");
    endtask

    // R8: continuing burst chained during the done cycle
    task automatic t_chain();
        issue(mk(1, 2, 0, 0, 0, 0, 4, 0, 0), 1'b0, 1'b0, 1'b1, "ch");
        @(negedge clk);
        tword_i = mk(9, 9, 0, 7, 2, 0, 5, 3, 0); tf_i = 1'b1; wr_i = 1'b1; cont_i = 1'b0;
        measure(1'b0);
        check_shape("R8 first access", 5, 3, 2);
        chk("R7 no early ack in burst", m_ack, 0);
        chk("R8 ack in done cycle", int'(m_ack_done), 1);
        @(negedge clk); req_i = 1'b0;
        measure(1'b1);
        check_shape("R8 chained no setup", 0, 8, 1);
        chk("R9 chained word exported", int'(udma_cyc_o), 2);
        after_done("ch");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_data_read();
        t_data_write_min();
        t_taskfile();
        t_busy_ignore();
        t_chain();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule